// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block sits at the front of a synchronous cache data RAM. It captures a word address when an address strobe is asserted. For the rest of a four-beat burst it then produces the follow-on array addresses. Every control input is sampled on the rising clock edge. The exceptions are the burst-order select, which is static, and the synchronous reset.

Two active-low strobes can start an access: a processor strobe and a controller strobe. They differ in how the first chip enable qualifies them. While the block is selected and no strobe is active, the advance input moves to the next beat or holds the current one. The two low address bits follow one of two orders. The wrap-around linear order adds a 2-bit count to the start value. The interleaved order XORs the count into the start value. The upper bits keep the value that was loaded. A registered selected flag and a two-bit cycle-type code report what the most recent edge did.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset clears the selected flag, sets the cycle type to deselect (code 0) and sets the address output to zero.
- R2: A qualified strobe with the chip enabled loads `addr_in`. This aborts any burst in progress. After that edge `selected` is 1, the cycle type is begin (code 1) and `mem_addr` equals the loaded address.
- R3: The chip counts as enabled only when `ce1_n` is 0, `ce2` is 1 and `ce3_n` is 0. A qualified strobe without this enable deselects the block: `selected` becomes 0, the code becomes 0, and the address output keeps its value.
- R4: With `ce1_n` high the processor strobe is ignored, and the cycle proceeds as if no strobe were present. With `ce1_n` high the controller strobe deselects the block.
- R5: While selected and with no effective strobe, `adv_n` low advances one beat (code 2, continue). `adv_n` high repeats the current address (code 3, suspend).
- R6: With `order_xor` low the two low address bits are the start value plus the beat count, modulo 4. A start of 01 gives 01, 10, 11, 00.
- R7: With `order_xor` high the two low address bits are the start value XOR the beat count. A start of 10 gives 10, 11, 00, 01.
- R8: Bits above bit 1 of `mem_addr` stay as loaded for the whole burst. `addr_in` has no effect unless a strobe is active.
- R9: While deselected and with no effective strobe, the block stays deselected (code 0) and the address output holds, whatever `adv_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External word address |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| order_xor | input | 1 | Static burst order: 0 linear, 1 interleaved |
| mem_addr | output | ADDR_W | Current array address |
| selected | output | 1 | Registered selected flag |
| cyc_type | output | 2 | 0 deselect, 1 begin, 2 continue, 3 suspend |

## Verification
Each result is due after exactly one rising edge. `selected` and `cyc_type` are registered and change on the edge that samples the inputs. `mem_addr` is decoded from the registered base and count, so it settles in the same cycle, just after that edge. The bench changes inputs on the falling edge and compares all three outputs 1 ns after the following rising edge. In that window the state from the sampled edge is settled and no new input has arrived.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              order_xor,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              selected,
  output logic [1:0]        cyc_type
);
  localparam logic [1:0] CY_DESEL = 2'd0;
  localparam logic [1:0] CY_BEGIN = 2'd1;
  localparam logic [1:0] CY_CONT  = 2'd2;
  localparam logic [1:0] CY_SUSP  = 2'd3;

  logic [ADDR_W-1:0] base;
  logic [1:0]        beat;
  logic [1:0]        low;

  wire chip_en  = !ce1_n && ce2 && !ce3_n;
  wire proc_go  = !proc_strb_n && !ce1_n;
  wire load_any = proc_go || !ctrl_strb_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      beat     <= '0;
      selected <= 1'b0;
      cyc_type <= CY_DESEL;
    end else if (load_any) begin
      if (chip_en) begin
        base     <= addr_in;
        beat     <= '0;
        selected <= 1'b1;
        cyc_type <= CY_BEGIN;
      end else begin
        selected <= 1'b0;
        cyc_type <= CY_DESEL;
      end
    end else if (selected) begin
      if (!adv_n) begin
        beat     <= 2'(beat + 2'd1);
        cyc_type <= CY_CONT;
      end else begin
        cyc_type <= CY_SUSP;
      end
    end
  end

  assign low      = order_xor ? (base[1:0] ^ beat) : 2'(base[1:0] + beat);
  assign mem_addr = {base[ADDR_W-1:2], low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              proc_strb_n,
  input logic              ctrl_strb_n,
  input logic              adv_n,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              order_xor,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              selected,
  input logic [1:0]        cyc_type
);
  wire enabled  = !ce1_n && ce2 && !ce3_n;
  wire no_strb  = ctrl_strb_n && (proc_strb_n || ce1_n);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!selected && cyc_type == 2'd0 && mem_addr == '0));

  p_begin_r2: assert property (@(posedge clk) disable iff (rst)
    ((!ctrl_strb_n || (!proc_strb_n && !ce1_n)) && enabled)
      |=> (selected && cyc_type == 2'd1 && mem_addr == $past(addr_in)));

  p_ctrl_desel_r4: assert property (@(posedge clk) disable iff (rst)
    (ce1_n && !ctrl_strb_n) |=> (!selected && cyc_type == 2'd0));

  p_suspend_r5: assert property (@(posedge clk) disable iff (rst)
    (selected && no_strb && adv_n) |=> (cyc_type == 2'd3 && $stable(mem_addr)));

  p_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (selected && no_strb) |=> $stable(mem_addr[ADDR_W-1:2]));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!selected && no_strb) |=> (!selected && $stable(mem_addr)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr_in(addr_in), .proc_strb_n(proc_strb_n),
  .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
  .ce3_n(ce3_n), .order_xor(order_xor), .mem_addr(mem_addr),
  .selected(selected), .cyc_type(cyc_type)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int ADDR_W = 17;
  localparam int NV = 24;

  logic              clk = 1'b0;
  logic              rst;
  logic [ADDR_W-1:0] addr_in;
  logic              proc_strb_n, ctrl_strb_n, adv_n, ce1_n, ce2, ce3_n, order_xor;
  logic [ADDR_W-1:0] mem_addr;
  logic              selected;
  logic [1:0]        cyc_type;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .proc_strb_n(proc_strb_n),
    .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .order_xor(order_xor), .mem_addr(mem_addr),
    .selected(selected), .cyc_type(cyc_type)
  );

  // {req[4], rst p_n c_n adv_n ce1_n ce2 ce3_n ord [8], addr_in[17], sel, cyc[2], exp_addr[17]}
  localparam logic [48:0] VEC [NV] = '{
    {4'd1, 8'b1111_1010, 17'h00000, 1'b0, 2'd0, 17'h00000},  // R1 reset
    {4'd2, 8'b0011_0100, 17'h00101, 1'b1, 2'd1, 17'h00101},  // R2 processor start
    {4'd8, 8'b0110_0100, 17'h1FFFF, 1'b1, 2'd2, 17'h00102},  // R8 addr_in ignored
    {4'd6, 8'b0110_0100, 17'h00000, 1'b1, 2'd2, 17'h00103},  // R6
    {4'd6, 8'b0110_0100, 17'h00000, 1'b1, 2'd2, 17'h00100},  // R6 wrap
    {4'd5, 8'b0111_0100, 17'h00000, 1'b1, 2'd3, 17'h00100},  // R5 suspend
    {4'd6, 8'b0110_0100, 17'h00000, 1'b1, 2'd2, 17'h00101},  // R6
    {4'd2, 8'b0101_0101, 17'h0ABC2, 1'b1, 2'd1, 17'h0ABC2},  // R2 controller start
    {4'd7, 8'b0110_0101, 17'h00000, 1'b1, 2'd2, 17'h0ABC3},  // R7
    {4'd7, 8'b0110_0101, 17'h00000, 1'b1, 2'd2, 17'h0ABC0},  // R7
    {4'd7, 8'b0110_0101, 17'h00000, 1'b1, 2'd2, 17'h0ABC1},  // R7
    {4'd4, 8'b0010_1101, 17'h00055, 1'b1, 2'd2, 17'h0ABC2},  // R4 processor strobe blocked
    {4'd3, 8'b0011_0001, 17'h00066, 1'b0, 2'd0, 17'h0ABC2},  // R3 ce2 low deselects
    {4'd9, 8'b0110_0101, 17'h00000, 1'b0, 2'd0, 17'h0ABC2},  // R9 idle holds
    {4'd2, 8'b0101_0100, 17'h00010, 1'b1, 2'd1, 17'h00010},  // R2
    {4'd4, 8'b0101_1100, 17'h00077, 1'b0, 2'd0, 17'h00010},  // R4 controller with ce1 high
    {4'd2, 8'b0011_0100, 17'h00020, 1'b1, 2'd1, 17'h00020},  // R2
    {4'd6, 8'b0110_0100, 17'h00000, 1'b1, 2'd2, 17'h00021},  // R6
    {4'd2, 8'b0101_0101, 17'h00035, 1'b1, 2'd1, 17'h00035},  // R2 abort mid burst
    {4'd7, 8'b0110_0101, 17'h00000, 1'b1, 2'd2, 17'h00034},  // R7
    {4'd7, 8'b0110_0101, 17'h00000, 1'b1, 2'd2, 17'h00037},  // R7
    {4'd5, 8'b0111_0101, 17'h00000, 1'b1, 2'd3, 17'h00037},  // R5 suspend
    {4'd7, 8'b0110_0101, 17'h00000, 1'b1, 2'd2, 17'h00036},  // R7
    {4'd3, 8'b0101_0111, 17'h00099, 1'b0, 2'd0, 17'h00036}   // R3 ce3_n high deselects
  };

  task automatic drive(input logic [7:0] c, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    {rst, proc_strb_n, ctrl_strb_n, adv_n, ce1_n, ce2, ce3_n, order_xor} = c;
    addr_in = a;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int req, input logic s, input logic [1:0] cy,
                       input logic [ADDR_W-1:0] ea);
    n_chk += 3;
    if (selected !== s) begin
      n_bad++; $display("FAIL R%0d selected act=%b exp=%b", req, selected, s);
    end
    if (cyc_type !== cy) begin
      n_bad++; $display("FAIL R%0d cyc_type act=%0d exp=%0d", req, cyc_type, cy);
    end
    if (mem_addr !== ea) begin
      n_bad++; $display("FAIL R%0d mem_addr act=%h exp=%h", req, mem_addr, ea);
    end
  endtask

  initial begin
    rst = 1'b1; proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; order_xor = 1'b0; addr_in = '0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][44:37], VEC[i][36:20]);
      check(int'(VEC[i][48:45]), VEC[i][19], VEC[i][18:17], VEC[i][16:0]);
    end
    // R1: reset in the middle of a burst
    drive(8'b0011_0100, 17'h00044);
    check(2, 1'b1, 2'd1, 17'h00044);
    drive(8'b0110_0100, 17'h00000);
    check(6, 1'b1, 2'd2, 17'h00045);
    drive(8'b1110_0100, 17'h00000);
    check(1, 1'b0, 2'd0, 17'h00000);
    // R3: both strobes, chip not enabled by ce2
    drive(8'b0001_0000, 17'h00123);
    check(3, 1'b0, 2'd0, 17'h00000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule